// File: doc/BRIEF.md
# Register Rename Status Table

This block holds the architectural register file of an out-of-order core together with a producer tag for every register. A tag of zero means the register holds a real value. A nonzero tag names the reservation station whose result will become the register's next value. Registers are never written through numbered write ports. They take values only by snooping a single result broadcast bus that carries a tag and a value.

At issue, two combinational source lookups each return one of two things. For a ready register they return the register's value with tag zero. For a pending register they return the producer tag. An arithmetic or load issue renames its destination register to the issuing station's tag. A store issue renames nothing. When a broadcast arrives in the same cycle as a lookup, the lookup forwards the broadcast value instead of a tag that has just gone stale.

Top module: `rename_status_table`

## Requirements
- R1: A synchronous reset clears every tag and every value to zero. After reset, any lookup returns value 0 with tag 0.
- R2: A lookup of a register whose tag is zero returns that register's stored value with tag 0.
- R3: A lookup of a register with a nonzero tag returns that tag with a value of zero.
- R4: An issue with `issueOp` 2'b00 (arithmetic) or 2'b01 (load) and a nonzero `issueTag` sets the destination's tag to `issueTag` from the next cycle on. This holds even when an older producer is still pending.
- R5: An issue with `issueOp` 2'b10 (store) or 2'b11 (reserved) changes no register.
- R6: A renaming issue with `issueTag` equal to zero changes no register.
- R7: A broadcast with nonzero tag t writes its value into every register whose tag equals t and clears those tags to zero, from the next cycle on.
- R8: A broadcast whose tag matches no register, or whose tag is zero, changes no register.
- R9: When a rename and a matching broadcast hit the same register in one cycle, the register keeps the new rename tag.
- R10: A lookup of a register whose tag equals the tag of a valid nonzero broadcast in the same cycle returns the broadcast value with tag 0.
- R11: Lookups show the state before any rename issued in the same cycle, so a source equal to the destination reads the old mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issueValid | input | 1 | An instruction issues this cycle |
| issueOp | input | 2 | Issue class: 00 arithmetic, 01 load, 10 store, 11 reserved |
| issueDst | input | IDX_W | Destination register index |
| issueTag | input | TAG_W | Tag of the issuing station |
| srcAIdx | input | IDX_W | First source register index |
| srcBIdx | input | IDX_W | Second source register index |
| srcAValue | output | DATA_W | First source value (zero while pending) |
| srcATag | output | TAG_W | First source producer tag (zero when ready) |
| srcBValue | output | DATA_W | Second source value (zero while pending) |
| srcBTag | output | TAG_W | Second source producer tag (zero when ready) |
| bcValid | input | 1 | Result broadcast valid |
| bcTag | input | TAG_W | Tag of the broadcasting station |
| bcValue | input | DATA_W | Broadcast result value |

## Verification
A corrupted tag in this block shows on the lookup outputs in the cycle the corrupted register is read. It does not wait for a later event. A lost rename reads back as a ready value where a tag is expected. A missed broadcast leaves a tag visible where a value should appear. The bench reads each register back through the lookup ports in the cycle after each rename or broadcast, and also in the same cycle to check forwarding. A wrong priority or a stale bypass is therefore reported within one clock.

// File: rtl/rnst_pkg.sv
package rnst_pkg;

  typedef enum logic [1:0] {
    OP_ARITH = 2'b00,
    OP_LOAD  = 2'b01,
    OP_STORE = 2'b10,
    OP_RSVD  = 2'b11
  } issue_op_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic renameEn;
    logic bcEn;
  } rnst_strobe_t;

endpackage

// File: rtl/rnst_ctrl.sv
module rnst_ctrl
  import rnst_pkg::*;
#(
  parameter int TAG_W = 3
) (
  input  logic             issueValid,
  input  logic [1:0]       issueOp,
  input  logic [TAG_W-1:0] issueTag,
  input  logic             bcValid,
  input  logic [TAG_W-1:0] bcTag,
  output rnst_strobe_t     strobes
);

  logic opRenames;

  always_comb begin
    unique case (issue_op_e'(issueOp))
      OP_ARITH, OP_LOAD: opRenames = 1'b1;
      default:           opRenames = 1'b0;
    endcase
  end

  // Tag zero is the "ready" code; it never names a station.
  always_comb begin
    strobes.renameEn = issueValid && opRenames && (issueTag != '0);
    strobes.bcEn     = bcValid && (bcTag != '0);
  end

endmodule

// File: rtl/rnst_datapath.sv
module rnst_datapath
  import rnst_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int TAG_W    = 3,
  parameter int DATA_W   = 16,
  parameter int NUM_SRC  = 2,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  rnst_strobe_t      strobes,
  input  logic [IDX_W-1:0]  issueDst,
  input  logic [TAG_W-1:0]  issueTag,
  input  logic [TAG_W-1:0]  bcTag,
  input  logic [DATA_W-1:0] bcValue,
  input  logic [IDX_W-1:0]  srcIdx [NUM_SRC],
  output logic [DATA_W-1:0] srcVal [NUM_SRC],
  output logic [TAG_W-1:0]  srcTag [NUM_SRC]
);

  logic [TAG_W-1:0]  tagQ [NUM_REGS];
  logic [DATA_W-1:0] valQ [NUM_REGS];

  // Per-register storage with rename-over-broadcast priority
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic renameHit;
    logic bcHit;

    assign renameHit = strobes.renameEn && (issueDst == IDX_W'(r));
    assign bcHit     = strobes.bcEn && (tagQ[r] == bcTag);

    always_ff @(posedge clk) begin
      if (rst) begin
        tagQ[r] <= '0;
        valQ[r] <= '0;
      end else if (renameHit) begin
        tagQ[r] <= issueTag;
      end else if (bcHit) begin
        tagQ[r] <= '0;
        valQ[r] <= bcValue;
      end
    end
  end

  // Read ports with same-cycle broadcast forwarding
  for (genvar p = 0; p < NUM_SRC; p++) begin : g_port
    logic [TAG_W-1:0]  curTag;
    logic [DATA_W-1:0] curVal;
    logic [TAG_W-1:0]  outTag;
    logic [DATA_W-1:0] outVal;

    assign curTag = tagQ[srcIdx[p]];
    assign curVal = valQ[srcIdx[p]];

    always_comb begin
      if (curTag == '0) begin
        outTag = '0;
        outVal = curVal;
      end else if (strobes.bcEn && (curTag == bcTag)) begin
        outTag = '0;
        outVal = bcValue;
      end else begin
        outTag = curTag;
        outVal = '0;
      end
    end

    assign srcTag[p] = outTag;
    assign srcVal[p] = outVal;
  end

endmodule

// File: rtl/rename_status_table.sv
module rename_status_table
  import rnst_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int TAG_W    = 3,
  parameter int DATA_W   = 16,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issueValid,
  input  logic [1:0]        issueOp,
  input  logic [IDX_W-1:0]  issueDst,
  input  logic [TAG_W-1:0]  issueTag,
  input  logic [IDX_W-1:0]  srcAIdx,
  input  logic [IDX_W-1:0]  srcBIdx,
  output logic [DATA_W-1:0] srcAValue,
  output logic [TAG_W-1:0]  srcATag,
  output logic [DATA_W-1:0] srcBValue,
  output logic [TAG_W-1:0]  srcBTag,
  input  logic              bcValid,
  input  logic [TAG_W-1:0]  bcTag,
  input  logic [DATA_W-1:0] bcValue
);

  localparam int NUM_SRC = 2;

  rnst_strobe_t      strobes;
  logic [IDX_W-1:0]  srcIdx [NUM_SRC];
  logic [DATA_W-1:0] srcVal [NUM_SRC];
  logic [TAG_W-1:0]  srcTag [NUM_SRC];

  assign srcIdx[0] = srcAIdx;
  assign srcIdx[1] = srcBIdx;

  rnst_ctrl #(.TAG_W(TAG_W)) u_ctrl (
    .issueValid (issueValid),
    .issueOp    (issueOp),
    .issueTag   (issueTag),
    .bcValid    (bcValid),
    .bcTag      (bcTag),
    .strobes    (strobes)
  );

  rnst_datapath #(
    .NUM_REGS (NUM_REGS),
    .TAG_W    (TAG_W),
    .DATA_W   (DATA_W),
    .NUM_SRC  (NUM_SRC)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .issueDst (issueDst),
    .issueTag (issueTag),
    .bcTag    (bcTag),
    .bcValue  (bcValue),
    .srcIdx   (srcIdx),
    .srcVal   (srcVal),
    .srcTag   (srcTag)
  );

  assign srcAValue = srcVal[0];
  assign srcATag   = srcTag[0];
  assign srcBValue = srcVal[1];
  assign srcBTag   = srcTag[1];

endmodule

// File: rtl/rnst_checker.sv
module rnst_checker #(
  parameter int NUM_REGS = 8,
  parameter int TAG_W    = 3,
  parameter int DATA_W   = 16,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              issueValid,
  input logic [1:0]        issueOp,
  input logic [IDX_W-1:0]  issueDst,
  input logic [TAG_W-1:0]  issueTag,
  input logic [IDX_W-1:0]  srcAIdx,
  input logic [DATA_W-1:0] srcAValue,
  input logic [TAG_W-1:0]  srcATag,
  input logic              bcValid,
  input logic [TAG_W-1:0]  bcTag
);

  logic prevRst = 1'b0;

  always_ff @(posedge clk) begin
    prevRst <= rst;
    if (prevRst && !rst) begin
      AST_RESET_READY: assert (srcATag == '0); // R1
    end
  end

  AST_PENDING_NO_VALUE: assert property (@(posedge clk) disable iff (rst)
    (srcATag != '0) |-> (srcAValue == '0)); // R3

  AST_RENAME_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (issueValid && !issueOp[1] && issueTag != '0) |=>
      ((srcAIdx != $past(issueDst)) || (bcValid && bcTag == $past(issueTag)) ||
       (srcATag == $past(issueTag)))); // R4

  AST_STORE_NO_RENAME: assert property (@(posedge clk) disable iff (rst)
    (issueValid && issueOp[1] && srcAIdx == issueDst && !bcValid) |=>
      (!$stable(srcAIdx) || bcValid || srcATag == $past(srcATag))); // R5

  AST_BYPASS_NO_STALE: assert property (@(posedge clk) disable iff (rst)
    (bcValid && bcTag != '0) |-> (srcATag != bcTag)); // R10

endmodule

bind rename_status_table rnst_checker #(
  .NUM_REGS (NUM_REGS),
  .TAG_W    (TAG_W),
  .DATA_W   (DATA_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .issueValid (issueValid),
  .issueOp    (issueOp),
  .issueDst   (issueDst),
  .issueTag   (issueTag),
  .srcAIdx    (srcAIdx),
  .srcAValue  (srcAValue),
  .srcATag    (srcATag),
  .bcValid    (bcValid),
  .bcTag      (bcTag)
);

// File: tb/sim_rename_status_table.sv
module sim_rename_status_table;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issueValid = 1'b0;
  logic [1:0]  issueOp = 2'b00;
  logic [2:0]  issueDst = '0;
  logic [2:0]  issueTag = '0;
  logic [2:0]  srcAIdx = '0;
  logic [2:0]  srcBIdx = '0;
  logic [15:0] srcAValue;
  logic [2:0]  srcATag;
  logic [15:0] srcBValue;
  logic [2:0]  srcBTag;
  logic        bcValid = 1'b0;
  logic [2:0]  bcTag = '0;
  logic [15:0] bcValue = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rename_status_table #(.NUM_REGS(8), .TAG_W(3), .DATA_W(16)) u0 (
    .clk(clk), .rst(rst),
    .issueValid(issueValid), .issueOp(issueOp), .issueDst(issueDst), .issueTag(issueTag),
    .srcAIdx(srcAIdx), .srcBIdx(srcBIdx),
    .srcAValue(srcAValue), .srcATag(srcATag), .srcBValue(srcBValue), .srcBTag(srcBTag),
    .bcValid(bcValid), .bcTag(bcTag), .bcValue(bcValue)
  );

  typedef struct packed {
    logic        iv;
    logic [1:0]  op;
    logic [2:0]  dst;
    logic [2:0]  tag;
    logic        bv;
    logic [2:0]  btag;
    logic [15:0] bval;
    logic [2:0]  sa;
    logic [2:0]  sb;
    logic [2:0]  aT;
    logic [15:0] aV;
    logic [2:0]  bT;
    logic [15:0] bV;
    logic [3:0]  req;
  } vec_t;

  // Each row is checked combinationally in its own cycle, before the edge.
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'd0, 3'd0, 3'd0, 1'b0, 3'd0, 16'h0000, 3'd0, 3'd7, 3'd0, 16'h0000, 3'd0, 16'h0000, 4'd1},  // R1 after reset
    '{1'b1, 2'd0, 3'd1, 3'd3, 1'b0, 3'd0, 16'h0000, 3'd1, 3'd2, 3'd0, 16'h0000, 3'd0, 16'h0000, 4'd11}, // R11 old mapping
    '{1'b1, 2'd1, 3'd2, 3'd5, 1'b0, 3'd0, 16'h0000, 3'd1, 3'd2, 3'd3, 16'h0000, 3'd0, 16'h0000, 4'd4},  // R4 arith rename seen
    '{1'b1, 2'd0, 3'd1, 3'd4, 1'b0, 3'd0, 16'h0000, 3'd1, 3'd2, 3'd3, 16'h0000, 3'd5, 16'h0000, 4'd3},  // R3 pending lookups
    '{1'b0, 2'd0, 3'd0, 3'd0, 1'b0, 3'd0, 16'h0000, 3'd1, 3'd2, 3'd4, 16'h0000, 3'd5, 16'h0000, 4'd4},  // R4 overwrite, load
    '{1'b0, 2'd0, 3'd0, 3'd0, 1'b1, 3'd3, 16'h1111, 3'd1, 3'd2, 3'd4, 16'h0000, 3'd5, 16'h0000, 4'd8},  // R8 stale tag bc
    '{1'b0, 2'd0, 3'd0, 3'd0, 1'b0, 3'd0, 16'h0000, 3'd1, 3'd2, 3'd4, 16'h0000, 3'd5, 16'h0000, 4'd8},  // R8 no change
    '{1'b1, 2'd0, 3'd3, 3'd5, 1'b0, 3'd0, 16'h0000, 3'd3, 3'd2, 3'd0, 16'h0000, 3'd5, 16'h0000, 4'd2},  // R2 ready lookup
    '{1'b0, 2'd0, 3'd0, 3'd0, 1'b1, 3'd5, 16'hABCD, 3'd3, 3'd2, 3'd0, 16'hABCD, 3'd0, 16'hABCD, 4'd10}, // R10 bypass both
    '{1'b0, 2'd0, 3'd0, 3'd0, 1'b0, 3'd0, 16'h0000, 3'd3, 3'd2, 3'd0, 16'hABCD, 3'd0, 16'hABCD, 4'd7},  // R7 two regs commit
    '{1'b1, 2'd2, 3'd4, 3'd6, 1'b0, 3'd0, 16'h0000, 3'd4, 3'd0, 3'd0, 16'h0000, 3'd0, 16'h0000, 4'd2},  // R2 store issue
    '{1'b0, 2'd0, 3'd0, 3'd0, 1'b0, 3'd0, 16'h0000, 3'd4, 3'd0, 3'd0, 16'h0000, 3'd0, 16'h0000, 4'd5},  // R5 store no rename
    '{1'b1, 2'd0, 3'd4, 3'd0, 1'b0, 3'd0, 16'h0000, 3'd4, 3'd0, 3'd0, 16'h0000, 3'd0, 16'h0000, 4'd2},  // R2 zero-tag issue
    '{1'b0, 2'd0, 3'd0, 3'd0, 1'b0, 3'd0, 16'h0000, 3'd4, 3'd0, 3'd0, 16'h0000, 3'd0, 16'h0000, 4'd6},  // R6 ignored
    '{1'b0, 2'd0, 3'd0, 3'd0, 1'b1, 3'd0, 16'h5555, 3'd3, 3'd4, 3'd0, 16'hABCD, 3'd0, 16'h0000, 4'd8},  // R8 zero-tag bc
    '{1'b0, 2'd0, 3'd0, 3'd0, 1'b0, 3'd0, 16'h0000, 3'd3, 3'd4, 3'd0, 16'hABCD, 3'd0, 16'h0000, 4'd8},  // R8 no change
    '{1'b1, 2'd0, 3'd1, 3'd6, 1'b1, 3'd4, 16'h7777, 3'd1, 3'd5, 3'd0, 16'h7777, 3'd0, 16'h0000, 4'd10}, // R10 with rename
    '{1'b0, 2'd0, 3'd0, 3'd0, 1'b0, 3'd0, 16'h0000, 3'd1, 3'd5, 3'd6, 16'h0000, 3'd0, 16'h0000, 4'd9},  // R9 rename wins
    '{1'b0, 2'd0, 3'd0, 3'd0, 1'b1, 3'd6, 16'h2468, 3'd1, 3'd6, 3'd0, 16'h2468, 3'd0, 16'h0000, 4'd10}, // R10 bypass
    '{1'b0, 2'd0, 3'd0, 3'd0, 1'b0, 3'd0, 16'h0000, 3'd1, 3'd6, 3'd0, 16'h2468, 3'd0, 16'h0000, 4'd7},  // R7 commit
    '{1'b1, 2'd3, 3'd5, 3'd2, 1'b0, 3'd0, 16'h0000, 3'd5, 3'd0, 3'd0, 16'h0000, 3'd0, 16'h0000, 4'd2},  // R2 reserved op
    '{1'b0, 2'd0, 3'd0, 3'd0, 1'b0, 3'd0, 16'h0000, 3'd5, 3'd0, 3'd0, 16'h0000, 3'd0, 16'h0000, 4'd5}   // R5 reserved no rename
  };

  task automatic checkPort(input string port, input int req,
                           input logic [2:0] gotT, input logic [15:0] gotV,
                           input logic [2:0] expT, input logic [15:0] expV);
    checks++;
    if (gotT !== expT || gotV !== expV) begin
      fails++;
      $display("FAIL R%0d port %s: tag=%0d value=%h, expected tag=%0d value=%h",
               req, port, gotT, gotV, expT, expV);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      issueValid = VECS[i].iv;
      issueOp    = VECS[i].op;
      issueDst   = VECS[i].dst;
      issueTag   = VECS[i].tag;
      bcValid    = VECS[i].bv;
      bcTag      = VECS[i].btag;
      bcValue    = VECS[i].bval;
      srcAIdx    = VECS[i].sa;
      srcBIdx    = VECS[i].sb;
      #1;
      checkPort("A", int'(VECS[i].req), srcATag, srcAValue, VECS[i].aT, VECS[i].aV);
      checkPort("B", int'(VECS[i].req), srcBTag, srcBValue, VECS[i].bT, VECS[i].bV);
      @(negedge clk);
    end

    // R1: reset clears committed values and beats a concurrent rename
    rst = 1'b1;
    issueValid = 1'b1; issueOp = 2'd0; issueDst = 3'd1; issueTag = 3'd7;
    bcValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    issueValid = 1'b0;
    srcAIdx = 3'd1; srcBIdx = 3'd3;
    #1;
    checkPort("A", 1, srcATag, srcAValue, 3'd0, 16'h0000); // R1
    checkPort("B", 1, srcBTag, srcBValue, 3'd0, 16'h0000); // R1

    // R4: load rename into a freshly reset table, then R7 commit
    @(negedge clk);
    issueValid = 1'b1; issueOp = 2'd1; issueDst = 3'd7; issueTag = 3'd2;
    @(negedge clk);
    issueValid = 1'b0;
    srcAIdx = 3'd7;
    #1;
    checkPort("A", 4, srcATag, srcAValue, 3'd2, 16'h0000); // R4
    @(negedge clk);
    bcValid = 1'b1; bcTag = 3'd2; bcValue = 16'hBEEF;
    @(negedge clk);
    bcValid = 1'b0;
    #1;
    checkPort("A", 7, srcATag, srcAValue, 3'd0, 16'hBEEF); // R7

    @(negedge clk);
    finishRun();
  end

endmodule